// File: doc/BRIEF.md
# Day and Seconds-of-Day Real-Time Clock

This block is a seconds-resolution real-time clock core. It keeps a 17-bit seconds-of-day count and a 15-bit day count. A one-cycle tick input advances the time by one second; it stands in for an external prescaler. Software reaches the clock through a small register bus. The time is split into a low byte, a 9-bit upper part and a day field, and a second set of registers holds an alarm time in the same layout.

Two interrupt sources are provided. One fires on every second tick; the other fires on a tick whose new time equals the alarm. Each source has a mask bit and a sticky status bit that software clears by writing a one. Because the time is spread over three narrow registers, the block fixes how writes commit and how carries travel. Software can then set the time by zeroing the low byte first, writing day and upper part, and writing the low byte last. It can read the time safely by re-reading the day whenever the upper part moved between its reads.

Top module: `secday_rtc`

## Requirements
- R1: On a tick with no clock write, the seconds count advances by one; a tick taken at 86399 (or at any larger value) gives 0 and adds one to the day count on that same clock edge.
- R2: Clock fields map as address 0 = seconds bits 7:0 in data bits 7:0, address 1 = seconds bits 16:8 in data bits 8:0, address 2 = day in data bits 14:0; reads return zero above each field and writes ignore the extra bits.
- R3: The day count is 15 bits and a carry out of day 32767 leaves it at 0.
- R4: Alarm fields sit at address 3 (low byte), 4 (upper 9 bits) and 5 (day 15 bits), with the same widths and zero fill as the clock fields.
- R5: Every tick sets update status, bit 0 of the status register at address 7, on the tick's clock edge.
- R6: Alarm status, bit 1 of address 7, is set only on a tick with no clock write whose resulting day and seconds both equal the alarm fields; cycles without a tick never set it.
- R7: A write to the day or upper field takes effect on its clock edge and is not disturbed by later ticks until the seconds carry into it; after the low byte is written with 0, 255 further ticks leave the upper field unchanged.
- R8: A carry from the low byte into the upper field, and from the upper field into day, lands on the same clock edge as the tick that causes it.
- R9: The mask register at address 6 enables update (bit 0) and alarm (bit 1) with 1 = enabled; irqOut is the OR of the enabled status bits; writing 1 to a status bit clears it, except that an event in the same cycle keeps it set.
- R10: When a clock field is written in the same cycle as a tick, the written value is stored and the tick's increment is dropped for the whole clock.
- R11: Reset clears seconds, day, alarm fields, mask and status to zero, and irqOut is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | One-cycle pulse, one per second |
| busAddr | input | 3 | Register address |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr, same cycle |
| irqOut | output | 1 | OR of enabled status bits |

## Verification
A bus write lands on the rising edge where busWe is high. Read data follows busAddr combinationally within the same cycle. Clock, status and irqOut change on the rising edge of the tick that causes them, so every result is due one edge after its stimulus. The bench drives inputs on the falling edge, lets one rising edge pass, and then reads the registers shortly after the next falling edge, before the following rising edge can move anything.

// File: rtl/secday_pkg.sv
`timescale 1ns/1ps
package secday_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;
  localparam int NSRC   = 2;

  localparam logic [ADDR_W-1:0] A_TOD_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_TOD_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_DAY    = 3'd2;
  localparam logic [ADDR_W-1:0] A_ALM_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_ALM_HI = 3'd4;
  localparam logic [ADDR_W-1:0] A_ALM_DAY = 3'd5;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd6;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd7;

  typedef struct packed {
    logic todLo;
    logic todHi;
    logic day;
    logic almLo;
    logic almHi;
    logic almDay;
    logic [DATA_W-1:0] wdata;
  } wrStrobe_t;
endpackage

// File: rtl/secday_dp.sv
`timescale 1ns/1ps
module secday_dp
  import secday_pkg::*;
#(
  parameter int LO_W     = 8,
  parameter int HI_W     = 9,
  parameter int DAY_W    = 15,
  parameter int SECS_DAY = 86400
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tickIn,
  input  wrStrobe_t               wr,
  output logic [LO_W+HI_W-1:0]    todQ,
  output logic [DAY_W-1:0]        dayQ,
  output logic [LO_W+HI_W-1:0]    almTodQ,
  output logic [DAY_W-1:0]        almDayQ,
  output logic                    tickEvt,
  output logic                    almHit
);
  localparam int TOD_W = LO_W + HI_W;
  localparam logic [TOD_W-1:0] LAST_SEC = TOD_W'(SECS_DAY - 1);

  logic              clkWr;
  logic              rollover;
  logic [TOD_W-1:0]  todInc;
  logic [DAY_W-1:0]  dayInc;

  assign clkWr    = wr.todLo | wr.todHi | wr.day;
  assign rollover = (todQ >= LAST_SEC);

  always_comb begin
    if (rollover) begin
      todInc = '0;
      dayInc = dayQ + 1'b1;
    end else begin
      todInc = todQ + 1'b1;
      dayInc = dayQ;
    end
  end

  // Clock fields: a write wins over the tick for the whole clock
  always_ff @(posedge clk) begin
    if (!rstN) begin
      todQ <= '0;
      dayQ <= '0;
    end else if (clkWr) begin
      if (wr.todLo) todQ[LO_W-1:0]     <= wr.wdata[LO_W-1:0];
      if (wr.todHi) todQ[TOD_W-1:LO_W] <= wr.wdata[HI_W-1:0];
      if (wr.day)   dayQ               <= wr.wdata[DAY_W-1:0];
    end else if (tickIn) begin
      todQ <= todInc;
      dayQ <= dayInc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      almTodQ <= '0;
      almDayQ <= '0;
    end else begin
      if (wr.almLo)  almTodQ[LO_W-1:0]     <= wr.wdata[LO_W-1:0];
      if (wr.almHi)  almTodQ[TOD_W-1:LO_W] <= wr.wdata[HI_W-1:0];
      if (wr.almDay) almDayQ               <= wr.wdata[DAY_W-1:0];
    end
  end

  assign tickEvt = tickIn;
  assign almHit  = tickIn && !clkWr && (todInc == almTodQ) && (dayInc == almDayQ);

  // R1: end-of-day tick returns seconds to zero and bumps day
  a_r1_rollover: assert property (@(posedge clk) disable iff (!rstN)
    (tickIn && !clkWr && todQ == LAST_SEC) |=>
      (todQ == '0 && dayQ == DAY_W'($past(dayQ) + 1'b1)));

  // R8: an ordinary tick moves seconds by one and leaves day alone
  a_r8_lockstep: assert property (@(posedge clk) disable iff (!rstN)
    (tickIn && !clkWr && todQ < LAST_SEC) |=>
      (todQ == TOD_W'($past(todQ) + 1'b1) && dayQ == $past(dayQ)));

  // R7: without tick or write the clock holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tickIn && !clkWr) |=> ($stable(todQ) && $stable(dayQ)));

  // R10: low-byte write is stored even with a tick present
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    wr.todLo |=> (todQ[LO_W-1:0] == $past(wr.wdata[LO_W-1:0])));
endmodule

// File: rtl/secday_ctrl.sv
`timescale 1ns/1ps
module secday_ctrl
  import secday_pkg::*;
#(
  parameter int LO_W  = 8,
  parameter int HI_W  = 9,
  parameter int DAY_W = 15
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWe,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  output logic                  irqOut,
  input  logic [LO_W+HI_W-1:0]  todQ,
  input  logic [DAY_W-1:0]      dayQ,
  input  logic [LO_W+HI_W-1:0]  almTodQ,
  input  logic [DAY_W-1:0]      almDayQ,
  input  logic                  tickEvt,
  input  logic                  almHit,
  output wrStrobe_t             wr
);
  localparam int TOD_W = LO_W + HI_W;

  logic [NSRC-1:0] maskQ;
  logic [NSRC-1:0] statQ;
  logic [NSRC-1:0] evt;
  logic [NSRC-1:0] clr;

  always_comb begin
    wr        = '0;
    wr.wdata  = busWdata;
    wr.todLo  = busWe && (busAddr == A_TOD_LO);
    wr.todHi  = busWe && (busAddr == A_TOD_HI);
    wr.day    = busWe && (busAddr == A_DAY);
    wr.almLo  = busWe && (busAddr == A_ALM_LO);
    wr.almHi  = busWe && (busAddr == A_ALM_HI);
    wr.almDay = busWe && (busAddr == A_ALM_DAY);
  end

  assign evt = {almHit, tickEvt};
  assign clr = (busWe && busAddr == A_STAT) ? busWdata[NSRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
      statQ <= '0;
    end else begin
      if (busWe && busAddr == A_MASK) maskQ <= busWdata[NSRC-1:0];
      statQ <= (statQ & ~clr) | evt;
    end
  end

  assign irqOut = |(statQ & maskQ);

  always_comb begin
    case (busAddr)
      A_TOD_LO:  busRdata = DATA_W'(todQ[LO_W-1:0]);
      A_TOD_HI:  busRdata = DATA_W'(todQ[TOD_W-1:LO_W]);
      A_DAY:     busRdata = DATA_W'(dayQ);
      A_ALM_LO:  busRdata = DATA_W'(almTodQ[LO_W-1:0]);
      A_ALM_HI:  busRdata = DATA_W'(almTodQ[TOD_W-1:LO_W]);
      A_ALM_DAY: busRdata = DATA_W'(almDayQ);
      A_MASK:    busRdata = DATA_W'(maskQ);
      default:   busRdata = DATA_W'(statQ);
    endcase
  end

  // R5: a tick always leaves update status set
  a_r5_update_set: assert property (@(posedge clk) disable iff (!rstN)
    tickEvt |=> statQ[0]);

  // R6: alarm events come only with a tick
  a_r6_tick_only: assert property (@(posedge clk) disable iff (!rstN)
    almHit |-> tickEvt);

  // R6: alarm status cannot rise without an alarm event
  a_r6_no_rise: assert property (@(posedge clk) disable iff (!rstN)
    (!statQ[1] && !almHit) |=> !statQ[1]);

  // R9: status is sticky until a one is written to it
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (statQ[0] && !clr[0]) |=> statQ[0]);
endmodule

// File: rtl/secday_rtc.sv
`timescale 1ns/1ps
module secday_rtc
  import secday_pkg::*;
#(
  parameter int LO_W     = 8,
  parameter int HI_W     = 9,
  parameter int DAY_W    = 15,
  parameter int SECS_DAY = 86400
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickIn,
  input  logic [2:0]   busAddr,
  input  logic         busWe,
  input  logic [15:0]  busWdata,
  output logic [15:0]  busRdata,
  output logic         irqOut
);
  localparam int TOD_W = LO_W + HI_W;

  wrStrobe_t          wr;
  logic [TOD_W-1:0]   todQ;
  logic [DAY_W-1:0]   dayQ;
  logic [TOD_W-1:0]   almTodQ;
  logic [DAY_W-1:0]   almDayQ;
  logic               tickEvt;
  logic               almHit;

  secday_ctrl #(.LO_W(LO_W), .HI_W(HI_W), .DAY_W(DAY_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut),
    .todQ(todQ), .dayQ(dayQ), .almTodQ(almTodQ), .almDayQ(almDayQ),
    .tickEvt(tickEvt), .almHit(almHit), .wr(wr)
  );

  secday_dp #(.LO_W(LO_W), .HI_W(HI_W), .DAY_W(DAY_W), .SECS_DAY(SECS_DAY)) uDp (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .wr(wr),
    .todQ(todQ), .dayQ(dayQ), .almTodQ(almTodQ), .almDayQ(almDayQ),
    .tickEvt(tickEvt), .almHit(almHit)
  );
endmodule

// File: tb/sim_secday_rtc.sv
`timescale 1ns/1ps
module sim_secday_rtc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        irqOut;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  secday_rtc u0 (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  // {start day, start seconds, ticks, expected day, expected seconds}
  localparam int NV = 6;
  localparam logic [71:0] VEC [NV] = '{
    {15'd0,     17'd0,     8'd5,  15'd0,  17'd5},    // R1 plain count
    {15'd1,     17'd255,   8'd1,  15'd1,  17'd256},  // R8 low-to-upper carry
    {15'd7,     17'd86399, 8'd1,  15'd8,  17'd0},    // R1 end of day
    {15'd32767, 17'd86398, 8'd2,  15'd0,  17'd0},    // R3 day wrap
    {15'd3,     17'd86390, 8'd20, 15'd4,  17'd10},   // R1 across midnight
    {15'd12,    17'd511,   8'd3,  15'd12, 17'd514}   // R8 upper carry
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic tickOnce();
    @(negedge clk);
    tickIn = 1'b1;
    @(negedge clk);
    tickIn = 1'b0;
  endtask

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) tickOnce();
  endtask

  task automatic writeWithTick(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1; tickIn = 1'b1;
    @(negedge clk);
    busWe = 1'b0; tickIn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic readTod(output logic [16:0] t);
    logic [15:0] lo, hi;
    busRead(3'd0, lo);
    busRead(3'd1, hi);
    t = {hi[8:0], lo[7:0]};
  endtask

  task automatic setClock(input logic [14:0] d, input logic [16:0] t);
    busWrite(3'd0, 16'h0000);
    busWrite(3'd2, {1'b0, d});
    busWrite(3'd1, {7'd0, t[16:8]});
    busWrite(3'd0, {8'd0, t[7:0]});
  endtask

  initial begin
    logic [15:0] v;
    logic [16:0] t;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11: everything zero after reset
    for (int a = 0; a < 8; a++) begin
      busRead(3'(a), v);
      check("R11 reset register", 32'(v), 32'd0);
    end
    #1 check("R11 reset irqOut", 32'(irqOut), 32'd0);

    // Vector walk: R1, R3, R8
    for (int i = 0; i < NV; i++) begin
      setClock(VEC[i][71:57], VEC[i][56:40]);
      tickN(int'(VEC[i][39:32]));
      busRead(3'd2, v);
      check("R1/R3/R8 vector day", 32'(v), 32'(VEC[i][31:17]));
      readTod(t);
      check("R1/R3/R8 vector seconds", 32'(t), 32'(VEC[i][16:0]));
    end

    // R2: zero fill above clock fields
    busWrite(3'd0, 16'hFFFF); busRead(3'd0, v); check("R2 low byte width", 32'(v), 32'h00FF);
    busWrite(3'd1, 16'hFFFF); busRead(3'd1, v); check("R2 upper width", 32'(v), 32'h01FF);
    busWrite(3'd2, 16'hFFFF); busRead(3'd2, v); check("R2 day width", 32'(v), 32'h7FFF);
    // R4: alarm fields, same widths
    busWrite(3'd3, 16'hFFFF); busRead(3'd3, v); check("R4 alarm low width", 32'(v), 32'h00FF);
    busWrite(3'd4, 16'hFFFF); busRead(3'd4, v); check("R4 alarm upper width", 32'(v), 32'h01FF);
    busWrite(3'd5, 16'hFFFF); busRead(3'd5, v); check("R4 alarm day width", 32'(v), 32'h7FFF);

    // R7: set protocol with ticks in between
    busWrite(3'd0, 16'h0000);
    tickN(3);
    busWrite(3'd2, 16'd5);
    tickOnce();
    busRead(3'd2, v); check("R7 day held in window", 32'(v), 32'd5);
    busWrite(3'd1, 16'd1);
    tickOnce();
    busRead(3'd1, v); check("R7 upper held in window", 32'(v), 32'd1);
    busWrite(3'd0, 16'h0022);
    readTod(t); check("R7 final low write commits", 32'(t), 32'd290);
    busRead(3'd2, v); check("R7 day after commit", 32'(v), 32'd5);
    // R7: 255 ticks after zeroing low byte do not reach upper field
    busWrite(3'd1, 16'd3);
    busWrite(3'd0, 16'd0);
    tickN(255);
    busRead(3'd1, v); check("R7 upper stable 255 ticks", 32'(v), 32'd3);
    busRead(3'd0, v); check("R7 low after 255 ticks", 32'(v), 32'd255);

    // R10: write and tick together
    writeWithTick(3'd0, 16'h0010);
    readTod(t); check("R10 write beats tick", 32'(t), 32'd784);
    busRead(3'd2, v); check("R10 day untouched", 32'(v), 32'd5);

    // R5 / R9: update interrupt
    busWrite(3'd7, 16'h0003);
    busRead(3'd7, v); check("R9 clear status", 32'(v), 32'd0);
    busWrite(3'd6, 16'h0001);
    tickOnce();
    busRead(3'd7, v); check("R5 update status", 32'(v), 32'd1);
    check("R9 irq enabled", 32'(irqOut), 32'd1);
    busWrite(3'd7, 16'h0001);
    busRead(3'd7, v); check("R9 w1c status", 32'(v), 32'd0);
    check("R9 irq after clear", 32'(irqOut), 32'd0);
    busWrite(3'd6, 16'h0000);
    tickOnce();
    busRead(3'd7, v); check("R5 status while masked", 32'(v), 32'd1);
    check("R9 irq masked", 32'(irqOut), 32'd0);
    writeWithTick(3'd7, 16'h0001);
    busRead(3'd7, v); check("R9 set wins over clear", 32'(v), 32'd1);

    // R6: alarm match
    busWrite(3'd5, 16'd2);
    busWrite(3'd4, 16'd0);
    busWrite(3'd3, 16'd100);
    setClock(15'd2, 17'd98);
    busWrite(3'd7, 16'h0003);
    tickOnce();
    busRead(3'd7, v); check("R6 no alarm at 99", 32'(v & 16'h2), 32'd0);
    tickOnce();
    busRead(3'd7, v); check("R6 alarm at 100", 32'(v & 16'h2), 32'h2);
    busWrite(3'd6, 16'h0002);
    #1 check("R9 alarm irq", 32'(irqOut), 32'd1);
    busWrite(3'd7, 16'h0002);
    repeat (5) @(negedge clk);
    busRead(3'd7, v); check("R6 one event per second", 32'(v & 16'h2), 32'd0);
    check("R9 irq low after alarm clear", 32'(irqOut), 32'd0);
    tickOnce();
    busRead(3'd7, v); check("R6 no alarm at 101", 32'(v & 16'h2), 32'd0);
    // R6: alarm at a day boundary
    busWrite(3'd5, 16'd3);
    busWrite(3'd3, 16'd0);
    setClock(15'd2, 17'd86399);
    busWrite(3'd7, 16'h0003);
    tickOnce();
    busRead(3'd7, v); check("R6 alarm on new day", 32'(v & 16'h2), 32'h2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule